// File: doc/BRIEF.md
# Key-Combination Reset Pulse Generator

This block watches a group of event inputs, such as decoded key presses, and sends out one reset pulse when every event selected by an enable mask has been held at the same time for a programmed hold time. An 8-bit configuration byte sets four things: the hold time, the pulse width, the active level of the output, and whether an external active-low reset also drives the output. The event inputs must already be clean, synchronous levels.

All timing is counted in ticks. A free-running prescaler makes one tick every `TICK_US` microseconds of the system clock, and the default tick is 250 µs. Hold times are whole multiples of a half-second unit of `HOLD_UNIT_TICKS` ticks. Pulse widths are multiples of a 500 µs unit of `PULSE_UNIT_TICKS` ticks. After a pulse the block stays disarmed until every enabled event has been released, so each long press gives exactly one pulse.

Top module: `keycombo_rst_gen`

## Requirements
- R1: Configuration bit 7 selects the output polarity. When the bit is 1 the pulse drives `rst_out` high and the idle level is low. When the bit is 0 the pulse drives it low and the idle level is high.
- R2: When configuration bit 6 is 1 and `ext_rst_n` is low, `rst_out` is at its active level in the same cycle, with no clock edge needed. When bit 6 is 0, `ext_rst_n` has no effect.
- R3: Configuration bits [5:2] give the hold code. The hold time in half-second units is: code 0 gives 0, codes 1 to 7 give code+1, and codes 8 to 15 give 2*code-6. Write T for that value times `HOLD_UNIT_TICKS`. With one tick per clock, if all enabled events are first sampled active at rising edge 1, the pulse starts after rising edge T+1.
- R4: Configuration bits [1:0] give the width code. Codes 00, 01, 10 and 11 give 1, 2, 4 and 20 units of `PULSE_UNIT_TICKS` ticks (500 µs, 1 ms, 2 ms, 10 ms). The output stays active for exactly that many ticks.
- R5: If any enabled event is sampled inactive before the hold time ends, the hold count goes back to zero. The full hold time is counted again from the next edge where all enabled events are active.
- R6: When `evt_en` is all zero, the block never starts a pulse. Event inputs whose enable bit is 0 have no effect on the timing.
- R7: After a pulse, no new pulse starts until every enabled event has been sampled inactive. Keeping the events held, or releasing only some of them, produces no second pulse.
- R8: One tick lasts (`CLK_HZ`/1,000,000)*`TICK_US` clock cycles, counted from reset. A pulse of W ticks therefore lasts between W*D-D+1 and W*D cycles, where D is the tick length in cycles.
- R9: The width and polarity in use when a pulse starts stay fixed until that pulse ends. Writing a new configuration during the pulse only affects the next press.
- R10: While `rst_n` is low at a rising edge, all counters clear, any pulse in progress ends, and `rst_out` goes to the idle level for the current bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 8 | Configuration byte: polarity, passthrough, hold code, width code |
| evt_en | input | N_EVT | Selects which events must be held together |
| evt | input | N_EVT | Event levels, 1 = active |
| ext_rst_n | input | 1 | External reset, active low |
| rst_out | output | 1 | Reset output, active level set by cfg bit 7 |

## Verification
The bench uses a one-clock tick, so every result lands on a known edge. Counting from the first rising edge that samples all enabled events active, the output changes after edge T+1 and returns to idle after edge T+W+1. The passthrough path is combinational and is checked one time step after its inputs change. Inputs are driven at falling edges and the output is sampled at the next falling edge, once per cycle across each press, so every cycle is compared against the value worked out from the code tables. A second instance with a four-clock tick checks the prescaler by measuring how long a pulse lasts, and accepts the one-tick window that comes from the prescaler phase.

// File: rtl/krg_pkg.sv
// Shared types and code tables for the key-combination reset generator.
// Assumes the caller scales the returned units into ticks.
package krg_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_PULSE   = 2'd1,
        ST_RELEASE = 2'd2
    } krg_state_e;

    // Configuration byte split into fields
    typedef struct packed {
        logic       pol_high;
        logic       pass_en;
        logic [3:0] hold_code;
        logic [1:0] width_code;
    } krg_cfg_t;

    // Hold code to half-second units: 0, then 2..8, then 10..24 in steps of two
    function automatic logic [4:0] hold_half_seconds(input logic [3:0] code);
        if (code == 4'd0)
            return 5'd0;
        else if (code <= 4'd7)
            return {1'b0, code} + 5'd1;
        else
            return {code, 1'b0} - 5'd6;
    endfunction

    // Width code to 500-microsecond units
    function automatic logic [4:0] width_units(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd2;
            2'd2:    return 5'd4;
            default: return 5'd20;
        endcase
    endfunction

endpackage

// File: rtl/krg_tick_gen.sv
// Free-running prescaler that outputs a one-cycle tick every TICK_US
// microseconds. Assumes CLK_HZ is a whole number of MHz. If the divide
// ratio comes out as 1 or less, the tick is high on every cycle.
module krg_tick_gen #(
    parameter int CLK_HZ  = 125_000_000,
    parameter int TICK_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV = (CLK_HZ / 1_000_000) * TICK_US;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt_q;

            // Count clock cycles within one tick period
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == CW'(DIV - 1));

            // A tick never lasts two cycles when the divide ratio is above one
            assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/krg_hold_timer.sv
// Measures how long all enabled events have been held together and raises
// 'fire' once the coded hold time has passed. Assumes the events are clean
// synchronous levels. Counts only while the controller is armed.
module krg_hold_timer
    import krg_pkg::*;
#(
    parameter int N_EVT           = 8,
    parameter int HOLD_UNIT_TICKS = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             armed,
    input  logic [N_EVT-1:0] evt,
    input  logic [N_EVT-1:0] evt_en,
    input  logic [3:0]       hold_code,
    output logic             fire,
    output logic             all_released
);
    localparam int MAX_T = 24 * HOLD_UNIT_TICKS;
    localparam int HW    = $clog2(MAX_T + 1);

    logic [HW-1:0] cnt_q;
    logic [HW-1:0] target;
    logic          all_on;

    // Decode the hold target and the group conditions of the events
    always_comb begin
        target       = HW'(int'(hold_half_seconds(hold_code)) * HOLD_UNIT_TICKS);
        all_on       = (evt_en != '0) && ((evt & evt_en) == evt_en);
        all_released = ((evt & evt_en) == '0);
        fire         = armed && all_on && (cnt_q >= target);
    end

    // Hold counter: restarts on any drop, saturates at the target
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!(armed && all_on))
            cnt_q <= '0;
        else if (tick && (cnt_q < target))
            cnt_q <= cnt_q + 1'b1;
    end

    // A broken hold leaves the counter at zero on the next cycle
    assert_hold_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && all_on) |=> (cnt_q == '0));

    // The counter never runs past the target
    assert_hold_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= HW'(MAX_T)));

endmodule

// File: rtl/krg_pulse_ctrl.sv
// Arming and pulse controller. When armed it takes 'fire', latches the pulse
// width and polarity, holds the pulse for that many ticks, then waits for
// every enabled event to be released before arming again.
module krg_pulse_ctrl
    import krg_pkg::*;
#(
    parameter int PULSE_UNIT_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       fire,
    input  logic       all_released,
    input  logic [1:0] width_code,
    input  logic       pol_in,
    output logic       armed,
    output logic       pulse_active,
    output logic       pol_latched
);
    localparam int MAX_W = 20 * PULSE_UNIT_TICKS;
    localparam int PW    = $clog2(MAX_W + 1);

    krg_state_e    state_q;
    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] width_q;
    logic          pol_q;

    // State sequencing, pulse timing and capture of the configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            pcnt_q  <= '0;
            width_q <= '0;
            pol_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_ARMED: begin
                    if (fire) begin
                        state_q <= ST_PULSE;
                        pcnt_q  <= '0;
                        width_q <= PW'(int'(width_units(width_code)) * PULSE_UNIT_TICKS);
                        pol_q   <= pol_in;
                    end
                end
                ST_PULSE: begin
                    if (tick) begin
                        if (pcnt_q == width_q - PW'(1)) begin
                            state_q <= ST_RELEASE;
                            pcnt_q  <= '0;
                        end else begin
                            pcnt_q <= pcnt_q + 1'b1;
                        end
                    end
                end
                ST_RELEASE: begin
                    if (all_released)
                        state_q <= ST_ARMED;
                end
                default: state_q <= ST_ARMED;
            endcase
        end
    end

    // Drive the status outputs from the state
    always_comb begin
        armed        = (state_q == ST_ARMED);
        pulse_active = (state_q == ST_PULSE);
        pol_latched  = pol_q;
    end

    // The pulse counter stays below the latched width
    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> (pcnt_q < width_q));

    // Waiting for release never leads straight into a new pulse
    assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASE) |=> (state_q != ST_PULSE));

    // Width and polarity hold still while a pulse runs
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PULSE) && $past(state_q == ST_PULSE)) |-> ($stable(width_q) && $stable(pol_q)));

endmodule

// File: rtl/keycombo_rst_gen.sv
// Top level of the key-combination reset generator. Connects the prescaler,
// the hold timer and the pulse controller, and builds the output from the
// pulse and the external reset in the selected polarity. Assumes cfg is
// stable, synchronous data and ext_rst_n is active low.
module keycombo_rst_gen
    import krg_pkg::*;
#(
    parameter int N_EVT            = 8,
    parameter int CLK_HZ           = 125_000_000,
    parameter int TICK_US          = 250,
    parameter int HOLD_UNIT_TICKS  = 2000,
    parameter int PULSE_UNIT_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cfg,
    input  logic [N_EVT-1:0] evt_en,
    input  logic [N_EVT-1:0] evt,
    input  logic             ext_rst_n,
    output logic             rst_out
);
    krg_cfg_t cfg_s;
    logic     tick;
    logic     fire;
    logic     all_released;
    logic     armed;
    logic     pulse_active;
    logic     pol_latched;
    logic     active;
    logic     pol_now;

    assign cfg_s = krg_cfg_t'(cfg);

    krg_tick_gen #(
        .CLK_HZ  (CLK_HZ),
        .TICK_US (TICK_US)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    krg_hold_timer #(
        .N_EVT           (N_EVT),
        .HOLD_UNIT_TICKS (HOLD_UNIT_TICKS)
    ) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .armed        (armed),
        .evt          (evt),
        .evt_en       (evt_en),
        .hold_code    (cfg_s.hold_code),
        .fire         (fire),
        .all_released (all_released)
    );

    krg_pulse_ctrl #(
        .PULSE_UNIT_TICKS (PULSE_UNIT_TICKS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .fire         (fire),
        .all_released (all_released),
        .width_code   (cfg_s.width_code),
        .pol_in       (cfg_s.pol_high),
        .armed        (armed),
        .pulse_active (pulse_active),
        .pol_latched  (pol_latched)
    );

    // Merge the pulse with the passthrough and apply the polarity
    always_comb begin
        active  = pulse_active || (cfg_s.pass_en && !ext_rst_n);
        pol_now = pulse_active ? pol_latched : cfg_s.pol_high;
        rst_out = pol_now ? active : !active;
    end

    // With no events enabled, a pulse never starts on its own
    assert_no_self_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_en == '0) && !pulse_active) |=> !pulse_active);

endmodule

// File: tb/keycombo_rst_gen_tb.sv
// Sweep bench for the key-combination reset generator. The main instance
// ticks every clock, so hold and pulse timing are checked cycle by cycle.
module keycombo_rst_gen_tb;
    localparam int NE = 4;
    localparam int HU = 2;
    localparam int PU = 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    cfg;
    logic [NE-1:0] en;
    logic [NE-1:0] evt;
    logic          ext_rst_n;
    logic          rst_out;
    logic          rst_out_div;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    keycombo_rst_gen #(.N_EVT(NE), .CLK_HZ(1_000_000), .TICK_US(1),
        .HOLD_UNIT_TICKS(HU), .PULSE_UNIT_TICKS(PU)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .evt_en(en), .evt(evt),
        .ext_rst_n(ext_rst_n), .rst_out(rst_out));

    keycombo_rst_gen #(.N_EVT(NE), .CLK_HZ(4_000_000), .TICK_US(1),
        .HOLD_UNIT_TICKS(HU), .PULSE_UNIT_TICKS(PU)) u_dut_div (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .evt_en(en), .evt(evt),
        .ext_rst_n(ext_rst_n), .rst_out(rst_out_div));

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int hold_ticks(input int code);
        int hs;
        if (code == 0) hs = 0;
        else if (code <= 7) hs = code + 1;
        else hs = 2 * code - 6;
        return hs * HU;
    endfunction

    function automatic int width_ticks(input int wc);
        int u;
        case (wc)
            0: u = 1;
            1: u = 2;
            2: u = 4;
            default: u = 20;
        endcase
        return u * PU;
    endfunction

    function automatic logic lvl(input bit pol, input bit act);
        return pol ? act : !act;
    endfunction

    // Press all enabled events and check every cycle against the expected shape
    task automatic press(input int hc, input int wc, input bit pol,
                         input logic [NE-1:0] m, input logic [NE-1:0] tog,
                         input int extra, input string req);
        int t;
        int w;
        t = hold_ticks(hc);
        w = width_ticks(wc);
        @(negedge clk);
        cfg = {pol, 1'b0, 4'(hc), 2'(wc)};
        en = m;
        evt = '0;
        ext_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        evt = m;
        for (int k = 1; k <= t + w + extra; k++) begin
            @(negedge clk);
            chk(rst_out, lvl(pol, (k >= t + 1) && (k <= t + w)), req);
            evt = evt ^ tog;
        end
        evt = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8 * 190_000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no finish expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        int cnt;
        rst_n = 1'b0;
        cfg = 8'h00;
        en = '0;
        evt = '0;
        ext_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: idle level while in reset, for both polarities
        chk(rst_out, 1'b1, "R10 reset idle pol0");
        cfg = 8'h80;
        #1 chk(rst_out, 1'b0, "R10 reset idle pol1");
        rst_n = 1'b1;

        // R1 R3 R4: sweep every hold code, width code and polarity
        for (int hc = 0; hc < 16; hc++)
            for (int wc = 0; wc < 4; wc++)
                for (int p = 0; p < 2; p++)
                    press(hc, wc, p[0], 4'b1111, 4'b0000, 2, "R1 R3 R4 sweep");

        // R6: a subset mask, with disabled events toggling every cycle
        press(1, 1, 1'b0, 4'b0101, 4'b1010, 3, "R6 masked events");
        press(9, 2, 1'b1, 4'b0011, 4'b1100, 3, "R6 masked events");

        // R6: nothing enabled, so no pulse ever starts
        @(negedge clk);
        cfg = 8'h00; en = '0; evt = 4'b1111;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            chk(rst_out, 1'b1, "R6 no enable");
        end
        evt = '0;

        // R5: drop one event on the cycle that would have fired
        t = hold_ticks(1);
        @(negedge clk);
        cfg = {1'b0, 1'b0, 4'd1, 2'd0}; en = 4'b1111; evt = '0;
        repeat (2) @(negedge clk);
        evt = 4'b1111;
        for (int k = 1; k <= t; k++) begin
            @(negedge clk);
            chk(rst_out, 1'b1, "R5 before drop");
        end
        evt = 4'b1011;
        @(negedge clk);
        chk(rst_out, 1'b1, "R5 drop blocks fire");
        evt = 4'b1111;
        for (int k = 1; k <= t + 2; k++) begin
            @(negedge clk);
            chk(rst_out, lvl(1'b0, k == t + 1), "R5 restart full hold");
        end
        evt = '0;
        repeat (2) @(negedge clk);

        // R7: long hold and partial release give no second pulse
        t = hold_ticks(1);
        cfg = {1'b1, 1'b0, 4'd1, 2'd1}; en = 4'b1111; evt = 4'b1111;
        for (int k = 1; k <= t + 2 + 10; k++) begin
            @(negedge clk);
            chk(rst_out, lvl(1'b1, (k >= t + 1) && (k <= t + 2)), "R7 held press");
        end
        evt = 4'b1110;
        @(negedge clk);
        evt = 4'b1111;
        for (int k = 1; k <= 2 * t + 4; k++) begin
            @(negedge clk);
            chk(rst_out, 1'b0, "R7 partial release");
        end
        evt = '0;
        repeat (2) @(negedge clk);
        evt = 4'b1111;
        for (int k = 1; k <= t + 3; k++) begin
            @(negedge clk);
            chk(rst_out, lvl(1'b1, (k >= t + 1) && (k <= t + 2)), "R7 rearmed");
        end
        evt = '0;
        repeat (2) @(negedge clk);

        // R9: change the width code during the pulse
        cfg = {1'b1, 1'b0, 4'd0, 2'd3};
        evt = 4'b1111;
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            chk(rst_out, lvl(1'b1, k <= 20), "R9 width latched");
            if (k == 5) cfg = {1'b1, 1'b0, 4'd0, 2'd0};
        end
        evt = '0;
        repeat (2) @(negedge clk);

        // R9: change the polarity during the pulse
        cfg = {1'b1, 1'b0, 4'd0, 2'd3};
        evt = 4'b1111;
        for (int k = 1; k <= 22; k++) begin
            @(negedge clk);
            chk(rst_out, 1'b1, "R9 polarity latched");
            if (k == 5) cfg = {1'b0, 1'b0, 4'd0, 2'd3};
        end
        evt = '0;
        repeat (2) @(negedge clk);

        // R2: passthrough follows ext_rst_n in the same cycle
        cfg = 8'h40; ext_rst_n = 1'b0;
        #1 chk(rst_out, 1'b0, "R2 pass active low");
        ext_rst_n = 1'b1;
        #1 chk(rst_out, 1'b1, "R2 pass released");
        cfg = 8'hC0; ext_rst_n = 1'b0;
        #1 chk(rst_out, 1'b1, "R2 pass active high");
        cfg = 8'h80;
        #1 chk(rst_out, 1'b0, "R2 pass disabled");
        ext_rst_n = 1'b1;

        // R10: a reset in the middle of a pulse ends it
        @(negedge clk);
        cfg = {1'b1, 1'b0, 4'd0, 2'd3}; evt = 4'b1111;
        repeat (3) @(negedge clk);
        chk(rst_out, 1'b1, "R10 pulse running");
        rst_n = 1'b0;
        @(negedge clk);
        chk(rst_out, 1'b0, "R10 reset ends pulse");
        evt = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R8: a four-clock tick stretches a 20-tick pulse to 77..80 cycles
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cfg = {1'b1, 1'b0, 4'd0, 2'd3}; en = 4'b1111; evt = 4'b1111;
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (rst_out_div) cnt++;
        end
        chk(cnt >= 77 && cnt <= 80, 1'b1, "R8 tick length");
        if (cnt < 77 || cnt > 80)
            $display("FAIL R8 detail: got %0d cycles expected 77..80", cnt);
        evt = '0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule